// File: doc/BRIEF.md
# Mode-Controlled Registered Bus Transceiver

This block is the data path of a bidirectional transceiver that sits between a card-side port (A) and a backplane-side port (B). Each port is modelled as separate input, output and output-enable vectors instead of tristate pins. Data is carried without inversion. It can pass straight through, be held by a level latch, or be captured on the rising edge of a chosen capture clock. The block also routes either the local system clock or a forwarded clock that arrives with backplane data. It sends the chosen clock to a forwarded-clock output and to a local clock output.

Four plain control pins set the behaviour. `dir` selects the transfer direction. `oe_n` disables all data outputs. `src_sync` selects which clock captures received data. `ck_en` chooses between transparent and stored data, and it also gates the clock outputs. The block runs on one core clock `clk`. The system clock and forwarded clock pins are sampled by `clk`, and a capture event is a 0-to-1 change between two samples that follow each other. The data ports are plain buses with no valid/ready handshake, because the transceiver has no notion of a transfer that can be refused. A value present on an input is reflected, or stored, according to the mode pins in force at that cycle.

Each direction has its own storage register. Register A holds port-A data meant for port B. Register B holds port-B data meant for port A.

Top module: `bidir_xcvr`

## Requirements
- R1: Data is noninverting in both directions: with `dir`=0 (A to B) the B output carries A data, and with `dir`=1 (B to A) the A output carries B data, bit for bit over all W bits.
- R2: `oe_n`=1 drives `a_oe` and `b_oe` low. With `oe_n`=0, `dir`=0 raises only `b_oe` and `dir`=1 raises only `a_oe`. A disabled data output reads all zeros.
- R3: With `ck_en`=1 the enabled data output follows the opposite port's input in the same cycle (transparent). The storage register of the selected direction also loads that input on every core clock edge.
- R4: When `ck_en` falls, the register keeps the value the input had at the last core clock edge where `ck_en` was still 1. The output then shows that value until the next capture event.
- R5: In the A-to-B direction with `ck_en`=0, register A loads `a_in` at the core edge where a rising system clock is first seen. Between such events the B output holds steady even if `a_in` changes.
- R6: In the B-to-A direction with `src_sync`=1, register B is captured on rising edges of the forwarded clock only. `fwd_clk_oe` is 0 (the forwarded clock is an input), and `loc_clk_out` equals `fwd_clk_in` while `ck_en`=1.
- R7: In the B-to-A direction with `src_sync`=0, register B is captured on rising edges of the system clock only. The clock outputs carry the system clock as in R8.
- R8: With `ck_en`=0, `fwd_clk_oe` and `loc_clk_out` are 0. With `ck_en`=1, the direction A to B, or B to A with `src_sync`=0, sets `fwd_clk_oe`=1, and both `fwd_clk_out` and `loc_clk_out` equal `sys_clk_in`. `fwd_clk_out` is 0 whenever `fwd_clk_oe` is 0.
- R9: With `oe_n`=1 (isolation), both registers keep capturing on their own capture events whatever `dir` is. The captured values appear once the outputs are enabled.
- R10: With `oe_n`=0, the register of the unselected direction never changes, so capture in one direction leaves the value held for the other intact.
- R11: During reset (`rst_n`=0) both data outputs are disabled, and both registers clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples clock pins and updates registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 0 = A to B, 1 = B to A |
| oe_n | input | 1 | 1 disables both data outputs |
| src_sync | input | 1 | 1 = receive data captured by the forwarded clock, 0 = by system clock |
| ck_en | input | 1 | 1 = transparent data and clock outputs on, 0 = stored data and clock outputs off |
| sys_clk_in | input | 1 | Local system clock pin (sampled) |
| fwd_clk_in | input | 1 | Forwarded clock received from the backplane |
| fwd_clk_out | output | 1 | Forwarded clock driven to the backplane |
| fwd_clk_oe | output | 1 | Drive enable of the forwarded clock |
| loc_clk_out | output | 1 | Local clock output |
| a_in | input | W | Port A input data |
| a_out | output | W | Port A output data |
| a_oe | output | 1 | Port A output enable |
| b_in | input | W | Port B input data |
| b_out | output | W | Port B output data |
| b_oe | output | 1 | Port B output enable |

## Verification
The assertions watch, on every cycle, that `oe_n` and reset disable the data outputs and that the clock outputs are switched off with `ck_en`. They also check the receive-clock routing in source-synchronous mode, that a system-clock rise in the A-to-B direction shows up on the B output one core edge later, that a falling `ck_en` freezes the last transparent value, and that the unselected register never moves. Only the bench scenarios can show which clock a mode actually captures with: forwarded pulses ignored in clock-synchronous receive and system pulses ignored in source-synchronous receive. They also show that values captured in isolation appear later, and that register contents survive direction changes. The bench's cycle model compares every output on every cycle through those sequences.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  localparam int LANE_W = 18;
  localparam int NUM_LANES = 2;
  localparam int NUM_CLK_PINS = 2;
  localparam int PIN_SYS = 0;
  localparam int PIN_FWD = 1;
  localparam int LANE_A = 0;
  localparam int LANE_B = 1;

  typedef enum logic {
    XFER_A2B = 1'b0,
    XFER_B2A = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bxcvr_edge.sv
module bxcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         cap_evt,
  input  logic         track,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hold <= '0;
    else if (cap_en && (track || cap_evt)) hold <= din;
  end
endmodule

// File: rtl/bxcvr_clkroute.sv
module bxcvr_clkroute
  import bxcvr_pkg::*;
(
  input  xfer_dir_e dir,
  input  logic      src_sync,
  input  logic      ck_en,
  input  logic      sys_clk_in,
  input  logic      fwd_clk_in,
  output logic      fwd_clk_out,
  output logic      fwd_clk_oe,
  output logic      loc_clk_out
);
  logic rx_forwarded;

  always_comb begin
    rx_forwarded = (dir == XFER_B2A) && src_sync;
    fwd_clk_oe   = ck_en && !rx_forwarded;
    fwd_clk_out  = fwd_clk_oe && sys_clk_in;
    loc_clk_out  = ck_en && (rx_forwarded ? fwd_clk_in : sys_clk_in);
  end
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
  import bxcvr_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir,
  input  logic         oe_n,
  input  logic         src_sync,
  input  logic         ck_en,
  input  logic         sys_clk_in,
  input  logic         fwd_clk_in,
  output logic         fwd_clk_out,
  output logic         fwd_clk_oe,
  output logic         loc_clk_out,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  xfer_dir_e                 xdir;
  logic [NUM_CLK_PINS-1:0]   clk_pins;
  logic [NUM_CLK_PINS-1:0]   pin_rise;
  logic [NUM_LANES-1:0]      cap_en;
  logic [NUM_LANES-1:0]      cap_evt;
  logic [W-1:0]              lane_din  [NUM_LANES];
  logic [W-1:0]              lane_hold [NUM_LANES];
  logic [W-1:0]              a_hold;
  logic [W-1:0]              b_hold;
  logic                      live;

  assign xdir = xfer_dir_e'(dir);
  assign clk_pins[PIN_SYS] = sys_clk_in;
  assign clk_pins[PIN_FWD] = fwd_clk_in;

  for (genvar g = 0; g < NUM_CLK_PINS; g++) begin : g_edge
    bxcvr_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (clk_pins[g]),
      .rise  (pin_rise[g])
    );
  end

  // Lane A stores port-A data bound for B; lane B stores port-B data bound for A.
  assign lane_din[LANE_A] = a_in;
  assign lane_din[LANE_B] = b_in;
  assign cap_en[LANE_A]   = (xdir == XFER_A2B) || oe_n;
  assign cap_en[LANE_B]   = (xdir == XFER_B2A) || oe_n;
  assign cap_evt[LANE_A]  = pin_rise[PIN_SYS];
  assign cap_evt[LANE_B]  = src_sync ? pin_rise[PIN_FWD] : pin_rise[PIN_SYS];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bxcvr_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en[g]),
      .cap_evt (cap_evt[g]),
      .track   (ck_en),
      .din     (lane_din[g]),
      .hold    (lane_hold[g])
    );
  end

  assign a_hold = lane_hold[LANE_A];
  assign b_hold = lane_hold[LANE_B];

  bxcvr_clkroute u_clkroute (
    .dir         (xdir),
    .src_sync    (src_sync),
    .ck_en       (ck_en),
    .sys_clk_in  (sys_clk_in),
    .fwd_clk_in  (fwd_clk_in),
    .fwd_clk_out (fwd_clk_out),
    .fwd_clk_oe  (fwd_clk_oe),
    .loc_clk_out (loc_clk_out)
  );

  assign live  = rst_n && !oe_n;
  assign b_oe  = live && (xdir == XFER_A2B);
  assign a_oe  = live && (xdir == XFER_B2A);
  assign b_out = b_oe ? (ck_en ? a_in : a_hold) : '0;
  assign a_out = a_oe ? (ck_en ? b_in : b_hold) : '0;
endmodule

// File: rtl/bxcvr_chk.sv
module bxcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir,
  input logic         oe_n,
  input logic         src_sync,
  input logic         ck_en,
  input logic         sys_clk_in,
  input logic         fwd_clk_in,
  input logic         fwd_clk_oe,
  input logic         loc_clk_out,
  input logic [W-1:0] a_in,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_hold,
  input logic [W-1:0] b_hold
);
  a_r2_oe_disables: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_oe, b_oe}));

  a_r8_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_en |-> (!loc_clk_out && !fwd_clk_oe));

  a_r6_rx_fwd_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && src_sync) |-> (!fwd_clk_oe && (loc_clk_out == (ck_en && fwd_clk_in))));

  a_r5_sys_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_in && !$past(sys_clk_in) && $past(rst_n) && !ck_en && !dir && !oe_n)
      |=> (ck_en || oe_n || dir || (b_out == $past(a_in))));

  a_r4_latch_close: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ck_en) && $past(rst_n) && !dir && !oe_n && $past(!dir))
      |-> (b_out == $past(a_in)));

  a_r10_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && !oe_n) |=> (b_hold == $past(b_hold)));

  a_r10_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !oe_n) |=> (a_hold == $past(a_hold)));

  always_comb begin
    a_r11_reset_off: assert (rst_n || (!a_oe && !b_oe));
  end
endmodule

bind bidir_xcvr bxcvr_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir         (dir),
  .oe_n        (oe_n),
  .src_sync    (src_sync),
  .ck_en       (ck_en),
  .sys_clk_in  (sys_clk_in),
  .fwd_clk_in  (fwd_clk_in),
  .fwd_clk_oe  (fwd_clk_oe),
  .loc_clk_out (loc_clk_out),
  .a_in        (a_in),
  .a_oe        (a_oe),
  .b_out       (b_out),
  .b_oe        (b_oe),
  .a_hold      (a_hold),
  .b_hold      (b_hold)
);

// File: tb/sim_bidir_xcvr.sv
module sim_bidir_xcvr;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0, oe_n = 1'b0, src_sync = 1'b0, ck_en = 1'b0;
  logic sys_clk_in = 1'b0, fwd_clk_in = 1'b0;
  logic fwd_clk_out, fwd_clk_oe, loc_clk_out;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir), .oe_n(oe_n), .src_sync(src_sync),
    .ck_en(ck_en), .sys_clk_in(sys_clk_in), .fwd_clk_in(fwd_clk_in),
    .fwd_clk_out(fwd_clk_out), .fwd_clk_oe(fwd_clk_oe), .loc_clk_out(loc_clk_out),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // Behavioural reference: two stored words and last sampled clock pins.
  logic [W-1:0] ref_a = '0, ref_b = '0;
  bit last_sys = 0, last_fwd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a <= '0; ref_b <= '0; last_sys <= 0; last_fwd <= 0;
    end else begin
      bit sys_up, fwd_up, b_clk_up;
      sys_up = sys_clk_in && !last_sys;
      fwd_up = fwd_clk_in && !last_fwd;
      b_clk_up = src_sync ? fwd_up : sys_up;
      if ((dir == 0 || oe_n) && (ck_en || sys_up)) ref_a <= a_in;
      if ((dir == 1 || oe_n) && (ck_en || b_clk_up)) ref_b <= b_in;
      last_sys <= sys_clk_in;
      last_fwd <= fwd_clk_in;
    end
  end

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic check_word(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%05h expected=%05h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit en, exp_b_oe, exp_a_oe, rx_fwd, exp_fwd_oe;
      logic [W-1:0] exp_b, exp_a;
      en = rst_n && !oe_n;
      exp_b_oe = en && (dir == 0);
      exp_a_oe = en && (dir == 1);
      exp_b = exp_b_oe ? (ck_en ? a_in : ref_a) : '0;
      exp_a = exp_a_oe ? (ck_en ? b_in : ref_b) : '0;
      rx_fwd = (dir == 1) && src_sync;
      exp_fwd_oe = ck_en && !rx_fwd;
      check_bit("b_oe", b_oe, exp_b_oe);
      check_bit("a_oe", a_oe, exp_a_oe);
      check_word("b_out", b_out, exp_b);
      check_word("a_out", a_out, exp_a);
      check_bit("fwd_clk_oe", fwd_clk_oe, exp_fwd_oe);
      check_bit("fwd_clk_out", fwd_clk_out, exp_fwd_oe && sys_clk_in);
      check_bit("loc_clk_out", loc_clk_out, ck_en && (rx_fwd ? fwd_clk_in : sys_clk_in));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic sys_pulse();
    sys_clk_in = 1'b1; step(2);
    sys_clk_in = 1'b0; step(2);
  endtask

  task automatic fwd_pulse();
    fwd_clk_in = 1'b1; step(2);
    fwd_clk_in = 1'b0; step(2);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: outputs off in reset even with oe_n low; registers cleared after.
    phase = "R11";
    a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    step(3);
    rst_n = 1'b1; step(3);
    dir = 1'b1; step(2);
    dir = 1'b0;

    // R1 / R3: transparent transfer in both directions.
    phase = "R1";
    ck_en = 1'b1;
    a_in = 18'h2AAAA; step(1);
    a_in = 18'h15555; step(1);
    a_in = 18'h00001; step(1);
    dir = 1'b1;
    b_in = 18'h20000; step(1);
    b_in = 18'h3C3C3; step(1);
    phase = "R3";
    b_in = 18'h12345; step(2);
    dir = 1'b0; a_in = 18'h0F0F0; step(2);

    // R8: clock outputs follow system clock when enabled, off when not.
    phase = "R8";
    sys_pulse(); sys_pulse();
    ck_en = 1'b0; sys_pulse();

    // R5: A-to-B capture on system clock rise only.
    phase = "R5";
    a_in = 18'h11111; step(2);
    sys_pulse();
    a_in = 18'h22222; step(3);
    sys_pulse();
    a_in = 18'h3ABCD; step(1);

    // R4: latch closes when ck_en falls.
    phase = "R4";
    ck_en = 1'b1; a_in = 18'h0BEEF; step(2);
    ck_en = 1'b0; a_in = 18'h1CAFE; step(4);

    // R6: source-synchronous receive uses forwarded clock only.
    phase = "R6";
    dir = 1'b1; src_sync = 1'b1;
    b_in = 18'h05A5A; fwd_pulse();
    b_in = 18'h3A5A5; sys_pulse();
    fwd_pulse();
    ck_en = 1'b1; fwd_pulse(); sys_pulse();
    ck_en = 1'b0;

    // R7: clock-synchronous receive uses system clock only.
    phase = "R7";
    src_sync = 1'b0;
    b_in = 18'h0C0DE; fwd_pulse();
    sys_pulse();
    ck_en = 1'b1; sys_pulse(); fwd_pulse();
    ck_en = 1'b0;

    // R9: isolation capture into both registers, shown later.
    phase = "R9";
    oe_n = 1'b1; a_in = 18'h13579; b_in = 18'h2468A;
    sys_pulse();
    a_in = '0; b_in = '0;
    oe_n = 1'b0; dir = 1'b0; step(2);
    dir = 1'b1; step(2);

    // R10: capture in one direction leaves the other register unchanged.
    phase = "R10";
    dir = 1'b0; a_in = 18'h0AAAA; b_in = 18'h3FFFF;
    sys_pulse(); sys_pulse();
    dir = 1'b1; step(2);
    b_in = 18'h01234; a_in = 18'h3EEEE;
    sys_pulse();
    dir = 1'b0; step(2);

    // R2: output enable gating in both directions.
    phase = "R2";
    ck_en = 1'b1; oe_n = 1'b1; step(2);
    dir = 1'b1; step(2);
    oe_n = 1'b0; step(2);
    dir = 1'b0; step(2);

    finish_run();
  end
endmodule